// File: doc/BRIEF.md
# Bitstream Counting Front End for a First-Order Sigma-Delta Converter

This block is the digital half of a first-order sigma-delta converter that sits on one I/O pin. An external resistor and capacitor integrate the input. A comparator turns the integrator state into a one-bit stream. The block synchronizes that bit and sends its inverse back out as the feedback drive, which closes the modulator loop. On every clock where the synchronized bit is high, a free-running accumulator advances by one. The accumulator therefore measures how long the bit stream is high, not how many times it toggles.

At the end of each programmable interval the block takes a snapshot of the accumulator. It subtracts the previous snapshot, then removes half of the interval length, so the mid-scale reference level reads as zero in two's complement. Full scale equals the interval length. A longer interval filters more and resolves more. The raw accumulator is also brought out, so that logic downstream can take its own differences at any time and apply any decimation it wants.

Top module: `sdfe_top`

## Requirements
- R1: `fbOut` is the logical inverse of `cmpIn` delayed by exactly two clocks (a two-flop synchronizer).
- R2: `rawCount` rises by exactly one on each clock whose synchronized comparator bit is high, holds otherwise, and is never cleared except by reset.
- R3: With interval length L in force, each sample equals the number of high synchronized bits counted over the last L clocks, minus floor(L/2). A stream that is high for k of every L clocks therefore reads k - floor(L/2).
- R4: An `intervalLen` value below 2 is treated as 2.
- R5: A change on `intervalLen` takes effect only at the next sample boundary. The interval already running finishes with its old length.
- R6: After reset, the first completed interval only records the baseline snapshot and produces no `sampleValid`.
- R7: `sampleValid` is high for exactly one clock per new sample, and `sampleOut` holds its value between pulses.
- R8: Snapshot differences use modulo arithmetic at the accumulator width, so samples stay correct when the accumulator wraps.
- R9: While reset is held, `sampleValid` is 0, `sampleOut` is 0, `rawCount` is 0 and `fbOut` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmpIn | input | 1 | Comparator bit stream from the pin |
| fbOut | output | 1 | Feedback drive, inverse of the synchronized comparator bit |
| intervalLen | input | LEN_W (16) | Sample interval in clocks, minimum 2 |
| sampleValid | output | 1 | One-clock strobe when a new sample is loaded |
| sampleOut | output | ACC_W (32) | Signed sample, two's complement |
| rawCount | output | ACC_W (32) | Free-running high-time accumulator |

## Verification
The bench sweeps every interval length from 2 to 16. For each length it tries every duty count k from 0 to L, so both odd and even halving are covered, as are the all-low and all-high extremes. A wrong offset or an off-by-one window would show up as a sample that misses k - floor(L/2).

A second instance has a 6-bit accumulator and runs the same sweep. It wraps many times, so a design that compared snapshots without modulo arithmetic would produce garbage samples there.

The spacing between strobes is measured across a change of interval. A design that applied the new length immediately would shorten or stretch the interval already in flight. Interval values of 0 and 1 must behave like 2. A missing baseline would raise a strobe within the first interval after reset.

// File: rtl/sdfe_pkg.sv
package sdfe_pkg;
  // strobes passed from the interval control to the datapath
  typedef struct packed {
    logic snap;   // capture accumulator as the new baseline
    logic emit;   // a full interval with a valid baseline has ended
  } sdfe_ctl_t;

  localparam int SYNC_STAGES = 2;
endpackage

// File: rtl/sdfe_ctrl.sv
module sdfe_ctrl
  import sdfe_pkg::*;
#(
  parameter int LEN_W   = 16,
  parameter int MIN_LEN = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LEN_W-1:0] intervalLen,
  output sdfe_ctl_t        ctl,
  output logic [LEN_W-1:0] curLen
);
  localparam logic [LEN_W-1:0] LEN_FLOOR = LEN_W'(MIN_LEN);

  logic             started;
  logic             hasBase;
  logic [LEN_W-1:0] remain;
  logic [LEN_W-1:0] lenClamped;
  logic             boundary;

  assign lenClamped = (intervalLen < LEN_FLOOR) ? LEN_FLOOR : intervalLen;
  assign boundary   = started && (remain == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      started <= 1'b0;
      hasBase <= 1'b0;
      remain  <= '0;
      curLen  <= LEN_FLOOR;
    end else if (!started) begin
      started <= 1'b1;
      curLen  <= lenClamped;
      remain  <= lenClamped - 1'b1;
    end else if (boundary) begin
      hasBase <= 1'b1;
      curLen  <= lenClamped;
      remain  <= lenClamped - 1'b1;
    end else begin
      remain  <= remain - 1'b1;
    end
  end

  always_comb begin
    ctl.snap = boundary;
    ctl.emit = boundary && hasBase;
  end

  // R5
  len_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (started && remain != '0) |=> $stable(curLen));

  // R4
  len_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    started |-> (curLen >= LEN_FLOOR));

  // R5
  remain_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    started |-> (remain < curLen));
endmodule

// File: rtl/sdfe_datapath.sv
module sdfe_datapath
  import sdfe_pkg::*;
#(
  parameter int ACC_W = 32,
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmpIn,
  input  sdfe_ctl_t        ctl,
  input  logic [LEN_W-1:0] curLen,
  output logic             fbOut,
  output logic             sampleValid,
  output logic [ACC_W-1:0] sampleOut,
  output logic [ACC_W-1:0] rawCount
);
  logic [SYNC_STAGES-1:0] syncQ;
  logic                   bitNow;
  logic [ACC_W-1:0]       acc;
  logic [ACC_W-1:0]       snapPrev;
  logic [ACC_W-1:0]       halfLen;
  logic [ACC_W-1:0]       delta;

  always_ff @(posedge clk) begin
    if (!rst_n) syncQ <= '0;
    else        syncQ <= {syncQ[SYNC_STAGES-2:0], cmpIn};
  end

  assign bitNow  = syncQ[SYNC_STAGES-1];
  assign fbOut   = ~bitNow;
  assign halfLen = ACC_W'(curLen >> 1);
  assign delta   = acc - snapPrev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc         <= '0;
      snapPrev    <= '0;
      sampleOut   <= '0;
      sampleValid <= 1'b0;
    end else begin
      acc         <= acc + ACC_W'(bitNow);
      sampleValid <= ctl.emit;
      if (ctl.snap) snapPrev  <= acc;
      if (ctl.emit) sampleOut <= delta - halfLen;
    end
  end

  assign rawCount = acc;

  // cycles since reset release, saturating, guards the delayed check
  logic [1:0] rstAge;
  always_ff @(posedge clk) begin
    if (!rst_n)               rstAge <= '0;
    else if (rstAge != 2'd3)  rstAge <= rstAge + 1'b1;
  end

  // R1
  fb_inverse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rstAge >= 2'd2) |-> (fbOut == !$past(cmpIn, 2)));

  // R2
  acc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rawCount - $past(rawCount)) <= ACC_W'(1));

  // R7
  strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sampleValid |=> !sampleValid);

  // R7
  sample_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sampleValid |-> $stable(sampleOut));
endmodule

// File: rtl/sdfe_top.sv
module sdfe_top
  import sdfe_pkg::*;
#(
  parameter int ACC_W = 32,
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmpIn,
  output logic             fbOut,
  input  logic [LEN_W-1:0] intervalLen,
  output logic             sampleValid,
  output logic [ACC_W-1:0] sampleOut,
  output logic [ACC_W-1:0] rawCount
);
  sdfe_ctl_t        ctl;
  logic [LEN_W-1:0] curLen;

  sdfe_ctrl #(.LEN_W(LEN_W), .MIN_LEN(2)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .intervalLen(intervalLen),
    .ctl(ctl), .curLen(curLen)
  );

  sdfe_datapath #(.ACC_W(ACC_W), .LEN_W(LEN_W)) dp_i (
    .clk(clk), .rst_n(rst_n), .cmpIn(cmpIn), .ctl(ctl), .curLen(curLen),
    .fbOut(fbOut), .sampleValid(sampleValid), .sampleOut(sampleOut),
    .rawCount(rawCount)
  );
endmodule

// File: tb/sdfe_top_tb_top.sv
module sdfe_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmpIn;
  logic [15:0] intervalLen;
  logic        fbOut, sampleValid;
  logic [31:0] sampleOut, rawCount;
  logic        fbW, validW;
  logic [5:0]  sampleW, rawW;

  int errs = 0;
  int checks = 0;
  int patPeriod = 1;
  int patHigh = 0;

  always #2 clk = ~clk;

  sdfe_top dut_i (
    .clk(clk), .rst_n(rst_n), .cmpIn(cmpIn), .fbOut(fbOut),
    .intervalLen(intervalLen), .sampleValid(sampleValid),
    .sampleOut(sampleOut), .rawCount(rawCount)
  );

  // narrow accumulator copy: wraps often (R8)
  sdfe_top #(.ACC_W(6), .LEN_W(16)) wrap_i (
    .clk(clk), .rst_n(rst_n), .cmpIn(cmpIn), .fbOut(fbW),
    .intervalLen(intervalLen), .sampleValid(validW),
    .sampleOut(sampleW), .rawCount(rawW)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  // bit stream generator: patHigh highs in every patPeriod clocks
  initial begin
    int phase = 0;
    cmpIn = 1'b0;
    forever begin
      @(negedge clk);
      cmpIn = (phase < patHigh);
      phase = (phase + 1 >= patPeriod) ? 0 : phase + 1;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  task automatic waitSample(output int v, output int w);
    do @(negedge clk); while (!sampleValid);
    v = $signed(sampleOut);
    w = $signed(sampleW);
  endtask

  initial begin
    int v, w, r0, gap;
    bit seen;
    logic [31:0] held;
    rst_n = 1'b0;
    intervalLen = 16'd8;
    repeat (5) @(negedge clk);
    // R9 reset state
    chk(sampleValid == 1'b0, "R9 valid", int'(sampleValid), 0);
    chk(sampleOut == 32'd0, "R9 sample", int'(sampleOut), 0);
    chk(rawCount == 32'd0, "R9 raw", int'(rawCount), 0);
    chk(fbOut == 1'b1, "R9 fb", int'(fbOut), 1);

    rst_n = 1'b1;
    // R6 baseline interval produces no strobe
    seen = 1'b0;
    for (int i = 0; i < 9; i++) begin
      @(negedge clk);
      if (sampleValid) seen = 1'b1;
    end
    chk(!seen, "R6 no strobe in baseline interval", int'(seen), 0);
    waitSample(v, w);
    chk(1'b1, "R6 first strobe arrives", 1, 1);

    // R1 feedback and R2 counting
    patPeriod = 1; patHigh = 1;
    repeat (4) @(negedge clk);
    chk(fbOut == 1'b0, "R1 fb while high", int'(fbOut), 0);
    r0 = int'(rawCount);
    @(negedge clk);
    chk(int'(rawCount) == r0 + 1, "R2 raw steps while high", int'(rawCount), r0 + 1);
    repeat (3) @(negedge clk);
    chk(int'(rawCount) == r0 + 4, "R2 raw steps over 3", int'(rawCount), r0 + 4);
    patHigh = 0;
    repeat (4) @(negedge clk);
    chk(fbOut == 1'b1, "R1 fb while low", int'(fbOut), 1);
    r0 = int'(rawCount);
    repeat (6) @(negedge clk);
    chk(int'(rawCount) == r0, "R2 raw holds while low", int'(rawCount), r0);

    // R3 / R8 sweep over interval and duty
    for (int L = 2; L <= 16; L++) begin
      for (int k = 0; k <= L; k++) begin
        intervalLen = 16'(L);
        patPeriod = L;
        patHigh = k;
        waitSample(v, w);
        waitSample(v, w);
        waitSample(v, w);
        chk(v == k - L / 2, $sformatf("R3 L=%0d k=%0d", L, k), v, k - L / 2);
        chk(w == k - L / 2, $sformatf("R8 wrap L=%0d k=%0d", L, k), w, k - L / 2);
      end
    end

    // R5 / R7 interval change waits for boundary
    intervalLen = 16'd8; patPeriod = 1; patHigh = 1;
    waitSample(v, w); waitSample(v, w); waitSample(v, w);
    intervalLen = 16'd12;
    held = sampleOut;
    @(negedge clk);
    chk(sampleValid == 1'b0, "R7 strobe one clock", int'(sampleValid), 0);
    gap = 1;
    while (!sampleValid) begin
      if (sampleOut != held) chk(1'b0, "R7 sample held", int'(sampleOut), int'(held));
      @(negedge clk);
      gap++;
    end
    chk(gap == 8, "R5 running interval keeps old length", gap, 8);
    gap = 0;
    do begin @(negedge clk); gap++; end while (!sampleValid);
    chk(gap == 12, "R5 new length after boundary", gap, 12);
    waitSample(v, w);
    chk(v == 6, "R3 full scale L=12", v, 6);

    // R4 floor at 2
    for (int s = 0; s < 2; s++) begin
      intervalLen = 16'(s);
      waitSample(v, w); waitSample(v, w); waitSample(v, w);
      chk(v == 1, $sformatf("R4 len=%0d sample", s), v, 1);
      gap = 0;
      do begin @(negedge clk); gap++; end while (!sampleValid);
      chk(gap == 2, $sformatf("R4 len=%0d spacing", s), gap, 2);
    end

    finishRun();
  end
endmodule